// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits between one hart's execution stage and a simple single-cycle memory port. It handles the two halves of an optimistic atomic sequence. A load-reserved request reads memory and remembers which bytes were read. A store-conditional request writes memory only if that memory is still reserved, and reports to the destination register whether the write happened.

A request is presented for one cycle with `req_valid`. The memory strobes are driven combinationally in that cycle, and `mem_rdata` is sampled in the same cycle. The response (`rsp_valid`, `rsp_data`, `rsp_misaligned`) appears registered in the following cycle.

The reservation is a single entry holding a granule base address and an access size. The granule is 4 bytes for a word access and 8 bytes for a doubleword access. The entry is lost on every executed store-conditional, on a snoop invalidate strobe from outside and on reset. A later load-reserved overwrites it.

Encodings: `req_cmd` 0 = load-reserved, 1 = store-conditional; `req_dword` 0 = word (32-bit), 1 = doubleword (64-bit).

Top module: `resv_monitor`

## Requirements
- R1: An aligned load-reserved asserts `mem_rd` (never together with `mem_wr`) in its request cycle, with `mem_addr` = `req_addr` and `mem_dword` = `req_dword`. Every request gives `rsp_valid` = 1 in the next cycle.
- R2: A word load-reserved returns `mem_rdata[31:0]` sign-extended from bit 31 to 64 bits. A doubleword load-reserved returns all 64 bits of `mem_rdata`.
- R3: An aligned load-reserved with no snoop in the same cycle records a reservation for its granule and size. Any earlier reservation is replaced.
- R4: A store-conditional succeeds when a reservation is held with the same granule base and the same size, and no snoop arrives in its cycle. On success it asserts `mem_wr` in the request cycle and returns `rsp_data` = 0. `mem_wdata` carries the store data; for a word store only bits 31:0 are meaningful.
- R5: A store-conditional that does not succeed asserts neither strobe and returns `rsp_data` = 1. This covers no reservation, a different address or a different size.
- R6: Every aligned store-conditional clears the reservation, whether it succeeds or fails, so an immediately repeated store-conditional fails.
- R7: A word access with `req_addr[1:0]` ≠ 0, or a doubleword access with `req_addr[2:0]` ≠ 0, is misaligned. It returns `rsp_misaligned` = 1 and `rsp_data` = 0, asserts no memory strobe, and leaves the reservation unchanged.
- R8: `snoop_inv` clears the reservation at the end of its cycle. A store-conditional in the same cycle fails. A load-reserved in the same cycle reads memory but records no reservation.
- R9: Synchronous reset clears the reservation and the response: `rsp_valid` = 0, so a store-conditional right after reset fails.
- R10: A cycle without `req_valid` asserts no memory strobe and gives `rsp_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 1 | 0 load-reserved, 1 store-conditional |
| req_dword | input | 1 | 0 word, 1 doubleword |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | XLEN | Store data for store-conditional |
| snoop_inv | input | 1 | External reservation kill strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_dword | output | 1 | Access size toward memory |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data, same cycle as `mem_rd` |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | XLEN | Loaded value or store-conditional status |
| rsp_misaligned | output | 1 | Request was misaligned |

## Verification
The bench builds the block with `ADDR_W` = 6 and `XLEN` = 64, a 64-byte address space. With that configuration it can pair every load-reserved address with every store-conditional address, for all four combinations of word and doubleword size. Each pair exercises the matching, mismatching and misaligned cases, and both sign-extension polarities, against a byte-array model of memory. Directed sequences add the cases the sweep cannot reach: snoop timing, replacement by a second load-reserved, repeated store-conditionals, a misaligned request between a reservation and its use, and reset in mid-sequence.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        CMD_LR = 1'b0,
        CMD_SC = 1'b1
    } resv_cmd_e;

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } resv_size_e;

    localparam int WORD_W       = 32;
    localparam int WORD_BYTES   = 4;
    localparam int DWORD_BYTES  = 8;
    localparam int SC_FAIL_CODE = 1;

    // low address bits that must be zero for the given size
    function automatic logic [2:0] align_mask(input resv_size_e sz);
        return (sz == SZ_DWORD) ? 3'(DWORD_BYTES - 1) : 3'(WORD_BYTES - 1);
    endfunction

    function automatic logic is_misaligned(input logic [2:0] low, input resv_size_e sz);
        return (low & align_mask(sz)) != 3'b000;
    endfunction

endpackage

// File: rtl/resv_align_chk.sv
module resv_align_chk
    import resv_pkg::*;
(
    input  logic [2:0]  addr_low,
    input  resv_size_e  size,
    output logic        misaligned
);

    always_comb begin
        misaligned = is_misaligned(addr_low, size);
    end

endmodule

// File: rtl/resv_load_fmt.sv
module resv_load_fmt
    import resv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  resv_size_e      size,
    output logic [XLEN-1:0] value
);

    localparam int EXT_W = XLEN - WORD_W;

    generate
        if (EXT_W > 0) begin : g_extend
            logic [XLEN-1:0] word_ext;
            always_comb begin
                word_ext = {{EXT_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
                value    = (size == SZ_DWORD) ? raw : word_ext;
            end
        end else begin : g_pass
            always_comb begin
                value = raw;
            end
        end
    endgenerate

endmodule

// File: rtl/resv_state.sv
module resv_state
    import resv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              drop_en,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] set_addr,
    input  resv_size_e        set_size,
    input  logic [ADDR_W-1:0] probe_addr,
    input  resv_size_e        probe_size,
    output logic              hit
);

    typedef struct packed {
        logic              valid;
        resv_size_e        size;
        logic [ADDR_W-1:0] base;
    } resv_t;

    resv_t             resv_q;
    logic [ADDR_W-1:0] set_base;
    logic [ADDR_W-1:0] probe_base;

    always_comb begin
        set_base   = set_addr   & ~ADDR_W'(align_mask(set_size));
        probe_base = probe_addr & ~ADDR_W'(align_mask(probe_size));
        hit        = resv_q.valid && !snoop_inv &&
                     (resv_q.size == probe_size) &&
                     (resv_q.base == probe_base);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '{valid: 1'b0, size: SZ_WORD, base: '0};
        end else if (snoop_inv || drop_en) begin
            resv_q.valid <= 1'b0;
        end else if (set_en) begin
            resv_q <= '{valid: 1'b1, size: set_size, base: set_base};
        end
    end

    AST_LR_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (set_en && !snoop_inv && !drop_en) |=>
            (resv_q.valid && resv_q.base == $past(set_base) && resv_q.size == $past(set_size))) // R3
        else $error("AST_LR_RECORDS");

    AST_SC_DROPS: assert property (@(posedge clk) disable iff (rst)
        drop_en |=> !resv_q.valid) // R6
        else $error("AST_SC_DROPS");

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        snoop_inv |=> !resv_q.valid) // R8
        else $error("AST_SNOOP_DROPS");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !drop_en && !snoop_inv) |=> $stable(resv_q)) // R7
        else $error("AST_IDLE_HOLDS");

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int XLEN   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_cmd,
    input  logic              req_dword,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic              snoop_inv,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_misaligned
);

    localparam int EXT_W = XLEN - WORD_W;

    typedef struct packed {
        logic            valid;
        logic            misal;
        logic [XLEN-1:0] data;
    } rsp_t;

    resv_cmd_e       cmd;
    resv_size_e      size;
    logic            misal;
    logic            lr_go;
    logic            sc_go;
    logic            resv_hit;
    logic [XLEN-1:0] ld_val;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    always_comb begin
        cmd  = resv_cmd_e'(req_cmd);
        size = resv_size_e'(req_dword);
    end

    resv_align_chk u_align (
        .addr_low   (req_addr[2:0]),
        .size       (size),
        .misaligned (misal)
    );

    always_comb begin
        lr_go = req_valid && (cmd == CMD_LR) && !misal;
        sc_go = req_valid && (cmd == CMD_SC) && !misal;
    end

    resv_state #(.ADDR_W(ADDR_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .set_en     (lr_go),
        .drop_en    (sc_go),
        .snoop_inv  (snoop_inv),
        .set_addr   (req_addr),
        .set_size   (size),
        .probe_addr (req_addr),
        .probe_size (size),
        .hit        (resv_hit)
    );

    resv_load_fmt #(.XLEN(XLEN)) u_fmt (
        .raw   (mem_rdata),
        .size  (size),
        .value (ld_val)
    );

    // memory side
    always_comb begin
        mem_rd    = lr_go;
        mem_wr    = sc_go && resv_hit;
        mem_addr  = req_addr;
        mem_dword = req_dword;
    end

    generate
        if (EXT_W > 0) begin : g_wdata_wide
            always_comb begin
                mem_wdata = (size == SZ_DWORD) ? req_wdata
                                               : {{EXT_W{1'b0}}, req_wdata[WORD_W-1:0]};
            end
        end else begin : g_wdata_narrow
            always_comb begin
                mem_wdata = req_wdata;
            end
        end
    endgenerate

    // response
    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.misal = req_valid && misal;
        if (!req_valid || misal) begin
            rsp_d.data = '0;
        end else if (cmd == CMD_LR) begin
            rsp_d.data = ld_val;
        end else if (resv_hit) begin
            rsp_d.data = '0;
        end else begin
            rsp_d.data = XLEN'(SC_FAIL_CODE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        rsp_valid      = rsp_q.valid;
        rsp_misaligned = rsp_q.misal;
        rsp_data       = rsp_q.data;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)) // R1
        else $error("AST_STROBE_EXCL");

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) // R1
        else $error("AST_RSP_FOLLOWS");

    AST_WORD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmd == CMD_LR && size == SZ_WORD && !misal) |=>
            (rsp_data[XLEN-1:WORD_W-1] == '0 || rsp_data[XLEN-1:WORD_W-1] == '1)) // R2
        else $error("AST_WORD_SIGN");

    AST_SC_ZERO_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (rsp_valid && rsp_data == '0)) // R4
        else $error("AST_SC_ZERO_ON_WRITE");

    AST_SC_FAIL_CODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmd == CMD_SC && !misal && !mem_wr) |=>
            (rsp_data == XLEN'(SC_FAIL_CODE))) // R5
        else $error("AST_SC_FAIL_CODE");

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && misal) |-> (!mem_rd && !mem_wr)) // R7
        else $error("AST_MISALIGN_QUIET");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid) // R10
        else $error("AST_IDLE_QUIET");

endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int XLEN       = 64;
    localparam int MEM_BYTES  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_cmd = 1'b0;
    logic              req_dword = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [XLEN-1:0]   req_wdata = '0;
    logic              snoop_inv = 1'b0;
    logic              mem_rd;
    logic              mem_wr;
    logic              mem_dword;
    logic [ADDR_W-1:0] mem_addr;
    logic [XLEN-1:0]   mem_wdata;
    logic [XLEN-1:0]   mem_rdata;
    logic              rsp_valid;
    logic [XLEN-1:0]   rsp_data;
    logic              rsp_misaligned;

    logic [7:0] mem_m [MEM_BYTES];

    int checks = 0;
    int errors = 0;

    // bench reservation model
    logic model_v = 1'b0;
    int   model_a = 0;
    logic model_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_resv_monitor (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_cmd        (req_cmd),
        .req_dword      (req_dword),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .snoop_inv      (snoop_inv),
        .mem_rd         (mem_rd),
        .mem_wr         (mem_wr),
        .mem_dword      (mem_dword),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .rsp_misaligned (rsp_misaligned)
    );

    // memory returns 8 bytes starting at the address, wrapping
    always_comb begin
        for (int k = 0; k < 8; k++) begin
            mem_rdata[8*k +: 8] = mem_m[(int'(mem_addr) + k) % MEM_BYTES];
        end
    end

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request; entered and left at a negative edge
    task automatic op(input logic cmd, input logic dw, input int addr,
                      input logic [XLEN-1:0] wd, input logic snp);
        logic            mis;
        logic            hit;
        logic [XLEN-1:0] raw;
        logic [XLEN-1:0] exp_data;
        int              nb;
        nb  = dw ? 8 : 4;
        mis = dw ? (addr % 8 != 0) : (addr % 4 != 0);
        hit = model_v && !snp && (model_a == addr) && (model_d == dw);
        for (int k = 0; k < 8; k++) raw[8*k +: 8] = mem_m[(addr + k) % MEM_BYTES];
        req_valid = 1'b1; req_cmd = cmd; req_dword = dw;
        req_addr = ADDR_W'(addr); req_wdata = wd; snoop_inv = snp;
        #1;
        if (mis) begin
            chk("R7 strobes quiet on misaligned", {62'b0, mem_rd, mem_wr}, 64'd0);
            exp_data = '0;
        end else if (cmd == 1'b0) begin
            chk("R1 load strobes", {62'b0, mem_rd, mem_wr}, 64'd2);
            chk("R1 load address/size", {57'b0, mem_dword, mem_addr}, {57'b0, dw, ADDR_W'(addr)});
            exp_data = dw ? raw : {{32{raw[31]}}, raw[31:0]};
        end else if (hit) begin
            chk("R4 store strobes", {62'b0, mem_rd, mem_wr}, 64'd1);
            chk("R4 store data", dw ? mem_wdata : {32'b0, mem_wdata[31:0]},
                dw ? wd : {32'b0, wd[31:0]});
            for (int k = 0; k < nb; k++) mem_m[(addr + k) % MEM_BYTES] = wd[8*k +: 8];
            exp_data = '0;
        end else begin
            chk("R5 failed store strobes", {62'b0, mem_rd, mem_wr}, 64'd0);
            exp_data = 64'd1;
        end
        // model update
        if (snp) model_v = 1'b0;
        else if (!mis && cmd == 1'b1) model_v = 1'b0;
        else if (!mis && cmd == 1'b0) begin
            model_v = 1'b1; model_a = addr; model_d = dw;
        end
        @(negedge clk);
        chk("R1 response valid", {63'b0, rsp_valid}, 64'd1);
        chk("R7 misaligned flag", {63'b0, rsp_misaligned}, {63'b0, mis});
        if (mis || cmd == 1'b1)
            chk(cmd ? "R5 store status" : "R7 misaligned data", rsp_data, exp_data);
        else
            chk(dw ? "R2 doubleword load" : "R2 word load sign", rsp_data, exp_data);
        req_valid = 1'b0; snoop_inv = 1'b0;
    endtask

    task automatic idle(input logic snp);
        req_valid = 1'b0; snoop_inv = snp;
        #1;
        chk("R10 idle strobes", {62'b0, mem_rd, mem_wr}, 64'd0);
        if (snp) model_v = 1'b0;
        @(negedge clk);
        chk("R10 idle response", {63'b0, rsp_valid}, 64'd0);
        snoop_inv = 1'b0;
    endtask

    // store-conditional whose outcome is named in the tag
    task automatic sc_expect(input string tag, input logic dw, input int addr,
                             input logic [XLEN-1:0] wd, input logic snp,
                             input logic [XLEN-1:0] exp_status);
        op(1'b1, dw, addr, wd, snp);
        chk(tag, rsp_data, exp_status);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem_m[i] = 8'((i * 37 + 5) ^ (i << 3));
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset response", {63'b0, rsp_valid}, 64'd0);
        chk("R9 reset strobes", {62'b0, mem_rd, mem_wr}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        sc_expect("R9 store after reset fails", 1'b0, 8, 64'h1111, 1'b0, 64'd1);

        // R10 idle
        idle(1'b0);

        // R3 replacement
        op(1'b0, 1'b0, 4, '0, 1'b0);
        op(1'b0, 1'b1, 16, '0, 1'b0);
        sc_expect("R3 replaced reservation fails", 1'b0, 4, 64'h22, 1'b0, 64'd1);
        op(1'b0, 1'b1, 16, '0, 1'b0);
        sc_expect("R3 newest reservation succeeds", 1'b1, 16, 64'h0123_4567_89AB_CDEF, 1'b0, 64'd0);

        // R6 repeated store
        op(1'b0, 1'b0, 20, '0, 1'b0);
        sc_expect("R6 first store succeeds", 1'b0, 20, 64'hFFFF_FFFF_8000_0001, 1'b0, 64'd0);
        sc_expect("R6 second store fails", 1'b0, 20, 64'h5, 1'b0, 64'd1);
        op(1'b0, 1'b0, 20, '0, 1'b0);
        sc_expect("R6 size mismatch fails", 1'b1, 16, 64'h5, 1'b0, 64'd1);
        sc_expect("R6 cleared by failing store", 1'b0, 20, 64'h5, 1'b0, 64'd1);

        // R8 snoop timing
        op(1'b0, 1'b1, 24, '0, 1'b0);
        idle(1'b1);
        sc_expect("R8 snoop between fails", 1'b1, 24, 64'h7, 1'b0, 64'd1);
        op(1'b0, 1'b1, 24, '0, 1'b1);
        sc_expect("R8 snoop with load fails", 1'b1, 24, 64'h7, 1'b0, 64'd1);
        op(1'b0, 1'b1, 24, '0, 1'b0);
        sc_expect("R8 snoop with store fails", 1'b1, 24, 64'h7, 1'b1, 64'd1);

        // R7 misaligned leaves reservation
        op(1'b0, 1'b0, 36, '0, 1'b0);
        op(1'b0, 1'b1, 44, '0, 1'b0);
        op(1'b1, 1'b0, 38, 64'h9, 1'b0);
        sc_expect("R7 reservation survives misaligned", 1'b0, 36, 64'hA5A5_5A5A, 1'b0, 64'd0);

        // R9 reset in mid-sequence
        op(1'b0, 1'b0, 48, '0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears response", {63'b0, rsp_valid}, 64'd0);
        rst = 1'b0; model_v = 1'b0;
        sc_expect("R9 store after mid reset fails", 1'b0, 48, 64'h3, 1'b0, 64'd1);

        // sweep: every load address against every store address, all sizes
        for (int ld = 0; ld < 2; ld++) begin
            for (int sd = 0; sd < 2; sd++) begin
                for (int la = 0; la < MEM_BYTES; la++) begin
                    for (int sa = 0; sa < MEM_BYTES; sa++) begin
                        op(1'b0, ld[0], la, '0, 1'b0);
                        op(1'b1, sd[0], sa,
                           64'hA5C3_0F1E_0000_0000 ^ (64'(la * MEM_BYTES + sa) * 64'h9E37_79B1), 1'b0);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule